// File: doc/BRIEF.md
# Integer ALU Instruction Form Decoder

This block sits at the front of an instruction pipeline and turns a stream of machine-code bytes into one decoded record per instruction, for the eight classic two-operand integer operations (add, or, add-with-carry, subtract-with-borrow, and, subtract, exclusive-or, compare). Bytes arrive one per accepted valid/ready transfer. The decoder tracks operand-size and register-extension prefixes, the opcode, the ModRM byte, an optional SIB byte, displacement bytes and immediate bytes. It consumes exactly the right number of bytes, so the next instruction starts on the correct byte.

When the last byte of an instruction has been taken, the record appears on the output in the following cycle. The record gives the operation, the operand form, the operand size, the extended register fields, the sign-extended immediate and the total length. It stays there until the consumer takes it, and no input byte is accepted in the meantime. A byte that does not belong to the supported family produces an error record, and decoding restarts at the byte after it.

The control is a state machine with six states. `S_PFX` takes prefixes and the opcode. `S_MODRM` takes the ModRM byte and `S_SIB` the SIB byte. `S_DISP` counts down displacement bytes, and `S_IMM` collects immediate bytes. `S_OUT` presents the record. The transitions are:
- Prefix: `S_PFX`→`S_PFX`.
- Opcode with ModRM: `S_PFX`→`S_MODRM`.
- Accumulator opcode: `S_PFX`→`S_IMM`.
- Unsupported byte or length overflow: any input state→`S_OUT`.
- SIB needed: `S_MODRM`→`S_SIB`.
- Displacement needed: `S_MODRM`/`S_SIB`→`S_DISP`.
- Immediate needed: `S_MODRM`/`S_SIB`/`S_DISP`→`S_IMM`.
- Instruction complete: any input state→`S_OUT`.
- Record consumed: `S_OUT`→`S_PFX`.

Top module: `alu_form_decoder`

## Requirements
- R1: A byte is taken on a clock edge where in_valid and in_ready are both high. After the last byte of an instruction is taken, out_valid is high in the next cycle. It stays high, with every output field stable, until out_ready is high. in_ready is low whenever out_valid is high.
- R2: For opcodes 0x00–0x3F whose low three bits are 0 to 5, out_op equals opcode bits 5:3. The codes are 0 add, 1 or, 2 add-with-carry, 3 subtract-with-borrow, 4 and, 5 subtract, 6 exclusive-or, 7 compare.
- R3: For those opcodes, low bits 0 and 1 give form MR (out_form=1), and low bits 2 and 3 give form RM (out_form=0). In other words, opcode bit 1 is the direction bit. Low bits 0 and 2 are the 8-bit variants.
- R4: Low bits 4 and 5 are the accumulator forms. They have no ModRM byte, out_form=3 (I), and out_reg=out_rm=0. Low bit 4 takes one immediate byte.
- R5: Opcodes 0x80, 0x81 and 0x83 are form MI (out_form=2). Their out_op comes from ModRM bits 5:3, with the same codes as R2.
- R6: out_size is 0 (8-bit) for opcodes 0x80 and low bits 0, 2 and 4. Otherwise it is 2 (32-bit). A 0x66 prefix gives 1 (16-bit). REX.W (bit 3 of a REX byte) gives 3 (64-bit) and overrides 0x66.
- R7: Opcodes 0x80 and 0x83 and low bit 4 carry one immediate byte. Opcode 0x81 and low bit 5 carry two immediate bytes under 0x66 without REX.W, and four otherwise. out_imm is the little-endian immediate sign-extended to 64 bits, and 0 when there is none.
- R8: A byte 0x40–0x4F counts as REX only when the next byte is the opcode. A 0x66 that follows it cancels it. out_reg is {REX.R (bit 2), ModRM 5:3} and out_rm is {REX.B (bit 0), ModRM 2:0}.
- R9: out_len counts prefixes, the opcode, ModRM, and SIB (when mod≠3 and r/m=4). It also counts one displacement byte for mod=1, four for mod=2, and four for mod=0 with r/m=5 or SIB base=5. Immediate bytes are counted last.
- R10: Any other byte in place of a prefix or opcode ends the instruction with out_err=1. out_len is then the number of bytes taken, and all other fields are 0. The next byte starts a new instruction.
- R11: If a byte leaves an instruction incomplete at MAX_LEN bytes, an error record is produced with out_len=MAX_LEN. An instruction that completes at exactly MAX_LEN bytes is valid.
- R12: During and after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is present |
| in_byte | input | 8 | Machine-code byte |
| in_ready | output | 1 | Decoder can take a byte |
| out_valid | output | 1 | Decoded record is present |
| out_ready | input | 1 | Consumer takes the record |
| out_err | output | 1 | Record is an error record |
| out_op | output | 3 | Operation code |
| out_form | output | 2 | 0 RM, 1 MR, 2 MI, 3 I |
| out_size | output | 2 | 0 8-bit, 1 16-bit, 2 32-bit, 3 64-bit |
| out_reg | output | 4 | Extended ModRM reg field |
| out_rm | output | 4 | Extended ModRM r/m field |
| out_imm | output | 64 | Sign-extended immediate |
| out_len | output | LEN_W | Instruction length in bytes |

## Verification
The assertions rely on the consumer side to follow the handshake. out_ready may be asserted in any cycle, but the decoder is expected to see no input transfers while a record waits. The assertions also take in_byte as meaningful only in cycles where in_valid is high. The stimulus holds each byte until it is taken and drives out_ready at random, which includes long stalls. It mixes well-formed instructions, misplaced prefixes, foreign opcodes and over-long prefix runs, and it never relies on a byte being taken while a record waits.

// File: rtl/afd_pkg.sv
package afd_pkg;

    typedef enum logic [2:0] {
        S_PFX,
        S_MODRM,
        S_SIB,
        S_DISP,
        S_IMM,
        S_OUT
    } dec_state_e;

    typedef enum logic [1:0] {
        FORM_RM = 2'd0,
        FORM_MR = 2'd1,
        FORM_MI = 2'd2,
        FORM_I  = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        SZ8  = 2'd0,
        SZ16 = 2'd1,
        SZ32 = 2'd2,
        SZ64 = 2'd3
    } size_e;

    typedef struct packed {
        logic       is_66;
        logic       is_rex;
        logic       is_alu;
        logic       has_modrm;
        logic       grp;
        logic       byte_op;
        form_e      form;
        logic [2:0] op;
        logic [2:0] imm_bytes;
    } opc_info_t;

    typedef struct packed {
        logic        err;
        logic [2:0]  op;
        form_e       form;
        size_e       size;
        logic [3:0]  reg_n;
        logic [3:0]  rm_n;
        logic [63:0] imm;
    } dec_rec_t;

endpackage

// File: rtl/afd_opcode_classify.sv
module afd_opcode_classify
    import afd_pkg::*;
(
    input  logic [7:0] opc,
    input  logic       osz16,
    input  logic       rexw,
    output opc_info_t  info
);

    logic [2:0] wide_bytes;

    always_comb begin
        wide_bytes = (osz16 && !rexw) ? 3'd2 : 3'd4;
        info = '0;
        info.form = FORM_RM;
        if (opc == 8'h66) begin
            info.is_66 = 1'b1;
        end else if (opc[7:4] == 4'h4) begin
            info.is_rex = 1'b1;
        end else if (opc[7:6] == 2'b00 && opc[2:1] != 2'b11) begin
            info.is_alu  = 1'b1;
            info.op      = opc[5:3];
            info.byte_op = !opc[0];
            unique case (opc[2:1])
                2'b00: begin
                    info.form      = FORM_MR;
                    info.has_modrm = 1'b1;
                end
                2'b01: begin
                    info.form      = FORM_RM;
                    info.has_modrm = 1'b1;
                end
                default: begin
                    info.form      = FORM_I;
                    info.imm_bytes = opc[0] ? wide_bytes : 3'd1;
                end
            endcase
        end else if (opc == 8'h80 || opc == 8'h81 || opc == 8'h83) begin
            info.is_alu    = 1'b1;
            info.has_modrm = 1'b1;
            info.grp       = 1'b1;
            info.form      = FORM_MI;
            info.byte_op   = (opc == 8'h80);
            info.imm_bytes = (opc == 8'h81) ? wide_bytes : 3'd1;
        end
    end

endmodule

// File: rtl/afd_addr_len.sv
module afd_addr_len (
    input  logic [7:0] modrm,
    input  logic [2:0] sib_base,
    output logic       need_sib,
    output logic [2:0] disp_plain,
    output logic [2:0] disp_sib
);

    logic [1:0] mod_f;
    logic [2:0] rm_f;

    always_comb begin
        mod_f    = modrm[7:6];
        rm_f     = modrm[2:0];
        need_sib = (mod_f != 2'd3) && (rm_f == 3'd4);
        unique case (mod_f)
            2'd1: begin
                disp_plain = 3'd1;
                disp_sib   = 3'd1;
            end
            2'd2: begin
                disp_plain = 3'd4;
                disp_sib   = 3'd4;
            end
            2'd0: begin
                disp_plain = (rm_f == 3'd5) ? 3'd4 : 3'd0;
                disp_sib   = (sib_base == 3'd5) ? 3'd4 : 3'd0;
            end
            default: begin
                disp_plain = 3'd0;
                disp_sib   = 3'd0;
            end
        endcase
    end

endmodule

// File: rtl/alu_form_decoder.sv
module alu_form_decoder
    import afd_pkg::*;
#(
    parameter int MAX_LEN = 15,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_err,
    output logic [2:0]       out_op,
    output logic [1:0]       out_form,
    output logic [1:0]       out_size,
    output logic [3:0]       out_reg,
    output logic [3:0]       out_rm,
    output logic [63:0]      out_imm,
    output logic [LEN_W-1:0] out_len
);

    dec_state_e       state_q, state_d;
    logic             osz16_q;
    logic [3:0]       rex_q;
    logic             rex_v_q;
    opc_info_t        info_q;
    logic [7:0]       modrm_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] cnt_inc;
    logic [2:0]       rem_q, rem_d;
    logic [31:0]      imm_q;
    logic [1:0]       imm_idx_q;
    dec_rec_t         rec_q;
    logic [LEN_W-1:0] len_q;

    opc_info_t        info_now;
    logic             fire;
    logic             finish;
    logic             bad;
    logic             over;
    logic [7:0]       modrm_cur;
    logic             need_sib;
    logic [2:0]       disp_plain;
    logic [2:0]       disp_sib;
    logic [31:0]      imm_cur;
    logic [63:0]      imm_ext;
    logic             rexw_eff;

    assign rexw_eff = rex_v_q && rex_q[3];
    assign in_ready = (state_q != S_OUT);
    assign fire     = in_valid && in_ready;
    assign cnt_inc  = cnt_q + 1'b1;
    assign modrm_cur = (state_q == S_MODRM) ? in_byte : modrm_q;

    afd_opcode_classify u_classify (
        .opc   (in_byte),
        .osz16 (osz16_q),
        .rexw  (rexw_eff),
        .info  (info_now)
    );

    afd_addr_len u_addr (
        .modrm      (modrm_cur),
        .sib_base   (in_byte[2:0]),
        .need_sib   (need_sib),
        .disp_plain (disp_plain),
        .disp_sib   (disp_sib)
    );

    // Immediate with the byte currently on the input merged in.
    always_comb begin
        imm_cur = imm_q;
        if (state_q == S_IMM) begin
            imm_cur[{imm_idx_q, 3'b000} +: 8] = in_byte;
        end
        unique case (info_q.imm_bytes)
            3'd1:    imm_ext = {{56{imm_cur[7]}}, imm_cur[7:0]};
            3'd2:    imm_ext = {{48{imm_cur[15]}}, imm_cur[15:0]};
            3'd4:    imm_ext = {{32{imm_cur[31]}}, imm_cur[31:0]};
            default: imm_ext = 64'd0;
        endcase
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        finish  = 1'b0;
        bad     = 1'b0;
        unique case (state_q)
            S_PFX: if (fire) begin
                if (info_now.is_66 || info_now.is_rex) begin
                    state_d = S_PFX;
                end else if (info_now.is_alu) begin
                    if (info_now.has_modrm) begin
                        state_d = S_MODRM;
                    end else begin
                        state_d = S_IMM;
                        rem_d   = info_now.imm_bytes;
                    end
                end else begin
                    bad = 1'b1;
                end
            end
            S_MODRM: if (fire) begin
                if (need_sib) begin
                    state_d = S_SIB;
                end else if (disp_plain != 3'd0) begin
                    state_d = S_DISP;
                    rem_d   = disp_plain;
                end else if (info_q.imm_bytes != 3'd0) begin
                    state_d = S_IMM;
                    rem_d   = info_q.imm_bytes;
                end else begin
                    finish = 1'b1;
                end
            end
            S_SIB: if (fire) begin
                if (disp_sib != 3'd0) begin
                    state_d = S_DISP;
                    rem_d   = disp_sib;
                end else if (info_q.imm_bytes != 3'd0) begin
                    state_d = S_IMM;
                    rem_d   = info_q.imm_bytes;
                end else begin
                    finish = 1'b1;
                end
            end
            S_DISP: if (fire) begin
                if (rem_q == 3'd1) begin
                    if (info_q.imm_bytes != 3'd0) begin
                        state_d = S_IMM;
                        rem_d   = info_q.imm_bytes;
                    end else begin
                        finish = 1'b1;
                    end
                end else begin
                    rem_d = rem_q - 3'd1;
                end
            end
            S_IMM: if (fire) begin
                if (rem_q == 3'd1) begin
                    finish = 1'b1;
                end else begin
                    rem_d = rem_q - 3'd1;
                end
            end
            S_OUT: if (out_ready) begin
                state_d = S_PFX;
            end
            default: state_d = S_PFX;
        endcase
        over = fire && !finish && !bad && (cnt_inc == LEN_W'(MAX_LEN));
        if (finish || bad || over) begin
            state_d = S_OUT;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_PFX;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    // Instruction context and result record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osz16_q   <= 1'b0;
            rex_q     <= '0;
            rex_v_q   <= 1'b0;
            info_q    <= '0;
            modrm_q   <= '0;
            cnt_q     <= '0;
            imm_q     <= '0;
            imm_idx_q <= '0;
            rec_q     <= '0;
            len_q     <= '0;
        end else if (state_q == S_OUT) begin
            if (out_ready) begin
                osz16_q   <= 1'b0;
                rex_q     <= '0;
                rex_v_q   <= 1'b0;
                info_q    <= '0;
                modrm_q   <= '0;
                cnt_q     <= '0;
                imm_q     <= '0;
                imm_idx_q <= '0;
            end
        end else if (fire) begin
            cnt_q <= cnt_inc;
            unique case (state_q)
                S_PFX: begin
                    if (info_now.is_66) begin
                        osz16_q <= 1'b1;
                        rex_v_q <= 1'b0;
                    end else if (info_now.is_rex) begin
                        rex_q   <= in_byte[3:0];
                        rex_v_q <= 1'b1;
                    end else begin
                        info_q <= info_now;
                    end
                end
                S_MODRM: modrm_q <= in_byte;
                S_IMM: begin
                    imm_q     <= imm_cur;
                    imm_idx_q <= imm_idx_q + 2'd1;
                end
                default: ;
            endcase
            if (finish || bad || over) begin
                len_q <= cnt_inc;
                rec_q <= '0;
                if (bad || over) begin
                    rec_q.err <= 1'b1;
                end else begin
                    rec_q.op   <= info_q.grp ? modrm_cur[5:3] : info_q.op;
                    rec_q.form <= info_q.form;
                    if (info_q.byte_op)  rec_q.size <= SZ8;
                    else if (rexw_eff)   rec_q.size <= SZ64;
                    else if (osz16_q)    rec_q.size <= SZ16;
                    else                 rec_q.size <= SZ32;
                    if (info_q.has_modrm) begin
                        rec_q.reg_n <= {rex_v_q & rex_q[2], modrm_cur[5:3]};
                        rec_q.rm_n  <= {rex_v_q & rex_q[0], modrm_cur[2:0]};
                    end
                    rec_q.imm <= imm_ext;
                end
            end
        end
    end

    // Output process.
    always_comb begin
        out_valid = (state_q == S_OUT);
        out_err   = rec_q.err;
        out_op    = rec_q.op;
        out_form  = rec_q.form;
        out_size  = rec_q.size;
        out_reg   = rec_q.reg_n;
        out_rm    = rec_q.rm_n;
        out_imm   = rec_q.imm;
        out_len   = len_q;
    end

    a_r1_no_take_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    a_r1_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_len) && $stable(out_imm)
                                       && $stable(out_err) && $stable(out_op)));

    a_r1_rise_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid));

    a_r11_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len != '0 && out_len <= LEN_W'(MAX_LEN)));

    a_r10_err_fields_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_imm == 64'd0 && out_reg == 4'd0 && out_rm == 4'd0));

    a_r4_acc_no_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err && out_form == 2'd3) |-> (out_reg == 4'd0 && out_rm == 4'd0));

endmodule

// File: tb/alu_form_decoder_tb.sv
module alu_form_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_LEN    = 15;
    localparam int LEN_W      = $clog2(MAX_LEN + 1);
    localparam int WATCHDOG   = 150000;

    typedef struct {
        bit      err;
        int      op;
        int      form;
        int      size;
        int      reg_n;
        int      rm_n;
        longint  imm;
        int      len;
        string   tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [7:0]       in_byte;
    logic             in_ready;
    logic             out_valid;
    logic             out_ready;
    logic             out_err;
    logic [2:0]       out_op;
    logic [1:0]       out_form;
    logic [1:0]       out_size;
    logic [3:0]       out_reg;
    logic [3:0]       out_rm;
    logic [63:0]      out_imm;
    logic [LEN_W-1:0] out_len;

    alu_form_decoder #(.MAX_LEN(MAX_LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_err(out_err), .out_op(out_op), .out_form(out_form),
        .out_size(out_size), .out_reg(out_reg), .out_rm(out_rm),
        .out_imm(out_imm), .out_len(out_len)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [7:0] stream[$];
    int         ends[$];
    exp_t       exp_q[$];
    int         errors = 0;
    int         checks = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint got, input longint want);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, want);
        end
    endtask

    // Behavioural model of one well-formed instruction.
    // rex_before_66: REX placed ahead of the 0x66 prefixes, so it is void.
    task automatic add_alu(input string tag, input int n66, input int rexv,
                           input bit rex_before_66, input int opc, input int modrm,
                           input int sib, input longint immv);
        exp_t e;
        int   start = stream.size();
        bit   grp = (opc == 'h80 || opc == 'h81 || opc == 'h83);
        int   low = opc & 7;
        bit   has_m = grp || (low < 4);
        int   rex_eff = rex_before_66 && n66 > 0 ? -1 : rexv;
        bit   w = (rex_eff >= 0) && ((rex_eff & 8) != 0);
        bit   s16 = (n66 > 0) && !w;
        bit   byteop = (opc == 'h80) || (!grp && (low == 0 || low == 2 || low == 4));
        int   mod_f = (modrm >> 6) & 3;
        int   rm_f = modrm & 7;
        int   ndisp = 0;
        int   nimm;
        longint raw = 0;
        if (rex_before_66 && rexv >= 0) stream.push_back(8'(rexv));
        for (int i = 0; i < n66; i++) stream.push_back(8'h66);
        if (!rex_before_66 && rexv >= 0) stream.push_back(8'(rexv));
        stream.push_back(8'(opc));
        e.err  = 0;
        e.tag  = tag;
        e.form = grp ? 2 : (low < 2) ? 1 : (low < 4) ? 0 : 3;
        e.op   = grp ? ((modrm >> 3) & 7) : ((opc >> 3) & 7);
        e.size = byteop ? 0 : w ? 3 : s16 ? 1 : 2;
        e.reg_n = 0;
        e.rm_n  = 0;
        if (has_m) begin
            stream.push_back(8'(modrm));
            e.reg_n = ((modrm >> 3) & 7) + ((rex_eff >= 0 && (rex_eff & 4) != 0) ? 8 : 0);
            e.rm_n  = rm_f + ((rex_eff >= 0 && (rex_eff & 1) != 0) ? 8 : 0);
            if (mod_f != 3 && rm_f == 4) stream.push_back(8'(sib));
            if (mod_f == 1) ndisp = 1;
            else if (mod_f == 2) ndisp = 4;
            else if (mod_f == 0 && (rm_f == 5 || (rm_f == 4 && (sib & 7) == 5))) ndisp = 4;
            for (int i = 0; i < ndisp; i++) stream.push_back(8'($urandom));
        end
        if (grp) nimm = (opc == 'h81) ? (s16 ? 2 : 4) : 1;
        else if (low == 4) nimm = 1;
        else if (low == 5) nimm = s16 ? 2 : 4;
        else nimm = 0;
        for (int i = 0; i < nimm; i++) begin
            stream.push_back(8'(immv >> (8 * i)));
            raw = raw | (((immv >> (8 * i)) & 64'hFF) << (8 * i));
        end
        if (nimm == 1) e.imm = longint'(byte'(raw));
        else if (nimm == 2) e.imm = longint'(shortint'(raw));
        else if (nimm == 4) e.imm = longint'(int'(raw));
        else e.imm = 0;
        e.len = stream.size() - start;
        ends.push_back(stream.size() - 1);
        exp_q.push_back(e);
    endtask

    // Error record: prefixes then a byte that ends the instruction as an error.
    task automatic add_bad(input string tag, input int n66, input int rexv, input int opc);
        exp_t e;
        int   start = stream.size();
        for (int i = 0; i < n66; i++) stream.push_back(8'h66);
        if (rexv >= 0) stream.push_back(8'(rexv));
        stream.push_back(8'(opc));
        e = '{err: 1, op: 0, form: 0, size: 0, reg_n: 0, rm_n: 0, imm: 0, len: 0, tag: tag};
        e.len = stream.size() - start;
        ends.push_back(stream.size() - 1);
        exp_q.push_back(e);
    endtask

    task automatic compare(input exp_t e);
        chk(out_err == e.err, {e.tag, "/R10"}, "err", longint'(out_err), longint'(e.err));
        chk(int'(out_len) == e.len, {e.tag, "/R9"}, "len", longint'(out_len), longint'(e.len));
        chk(int'(out_op) == e.op, {e.tag, "/R2"}, "op", longint'(out_op), longint'(e.op));
        chk(int'(out_form) == e.form, {e.tag, "/R3"}, "form", longint'(out_form), longint'(e.form));
        chk(int'(out_size) == e.size, {e.tag, "/R6"}, "size", longint'(out_size), longint'(e.size));
        chk(longint'(out_imm) == e.imm, {e.tag, "/R7"}, "imm", longint'(out_imm), e.imm);
        chk(int'(out_reg) == e.reg_n, {e.tag, "/R8"}, "reg", longint'(out_reg), longint'(e.reg_n));
        chk(int'(out_rm) == e.rm_n, {e.tag, "/R8"}, "rm", longint'(out_rm), longint'(e.rm_n));
    endtask

    initial begin
        int  sidx = 0;
        int  cyc = 0;
        bit  want_out = 0;
        int  bad_set[8] = '{'h06, 'h07, 'h0F, 'h82, 'h90, 'h67, 'h26, 'hF0};
        int  grp_set[3] = '{'h80, 'h81, 'h83};

        // Directed cases.
        add_alu("R4", 0, -1, 0, 'h04, 0, 0, 64'h85);
        add_alu("R3", 0, -1, 0, 'h00, 'hC8, 0, 0);
        add_alu("R3", 0, -1, 0, 'h02, 'hC8, 0, 0);
        add_alu("R2", 0, -1, 0, 'h39, 'hD1, 0, 0);
        add_alu("R5", 0, -1, 0, 'h80, 'hF8, 0, 64'h7F);
        add_alu("R5", 0, 'h48, 0, 'h83, 'hE8, 0, 64'hF0);
        add_alu("R7", 1, -1, 0, 'h81, 'hC3, 0, 64'h8001);
        add_alu("R7", 1, 'h48, 0, 'h05, 0, 0, 64'h80000000);
        add_alu("R6", 0, -1, 0, 'h25, 0, 0, 64'h12345678);
        add_alu("R8", 1, 'h48, 1, 'h01, 'hC0, 0, 0);
        add_alu("R8", 0, 'h45, 0, 'h31, 'hDA, 0, 0);
        add_alu("R9", 0, -1, 0, 'h01, 'h04, 'h25, 0);
        add_alu("R9", 0, -1, 0, 'h03, 'h05, 0, 0);
        add_alu("R9", 0, -1, 0, 'h81, 'h84, 'h11, 64'hCAFEF00D);
        add_alu("R9", 0, -1, 0, 'h83, 'h40, 0, 64'h01);
        add_bad("R10", 0, -1, 'h0F);
        add_bad("R10", 1, 'h48, 'h90);
        add_alu("R10", 0, -1, 0, 'h28, 'hC1, 0, 0);
        add_bad("R11", 14, -1, 'h04);
        add_alu("R11", 13, -1, 0, 'h04, 0, 0, 64'hFF);

        // Random mix.
        for (int n = 0; n < 300; n++) begin
            int     r = $urandom % 12;
            int     n66 = ($urandom % 3 == 0) ? 1 : 0;
            int     rexv = ($urandom % 2 == 0) ? int'('h40 | ($urandom % 16)) : -1;
            longint immv = {$urandom, $urandom};
            if (r < 7)
                add_alu("R2", n66, rexv, $urandom % 4 == 0,
                        (($urandom % 8) << 3) | ($urandom % 6), $urandom % 256,
                        $urandom % 256, immv);
            else if (r < 10)
                add_alu("R5", n66, rexv, 0, grp_set[$urandom % 3], $urandom % 256,
                        $urandom % 256, immv);
            else
                add_bad("R10", n66, rexv, bad_set[$urandom % 8]);
        end

        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_byte   = 8'h00;
        out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R12", "out_valid in reset", longint'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R12", "out_valid after reset", longint'(out_valid), 0);
        chk(in_ready == 1'b1, "R12", "in_ready after reset", longint'(in_ready), 1);

        while ((sidx < stream.size() || exp_q.size() > 0) && cyc < WATCHDOG) begin
            if (cyc > 0) @(negedge clk);
            cyc++;
            if (want_out) begin
                chk(out_valid == 1'b1, "R1", "valid after last byte", longint'(out_valid), 1);
                want_out = 0;
            end
            if (out_valid)
                chk(in_ready == 1'b0, "R1", "ready while pending", longint'(in_ready), 0);
            in_valid  = (sidx < stream.size()) && ($urandom % 5 != 0);
            in_byte   = in_valid ? stream[sidx] : 8'h00;
            out_ready = ($urandom % 3 != 0);
            if (in_valid && in_ready) begin
                if (ends.size() > 0 && sidx == ends[0]) begin
                    want_out = 1;
                    void'(ends.pop_front());
                end
                sidx++;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0)
                    chk(0, "R1", "unexpected record", 1, 0);
                else
                    compare(exp_q.pop_front());
            end
        end
        if (cyc >= WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: got %0d cycles expected below %0d", cyc, WATCHDOG);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule